// File: doc/BRIEF.md
# CRT Controller Display Address Generator

This block produces the address that a legacy-compatible CRT controller presents to display memory. It keeps a linear character address counter and loads it from a start address at the top of each frame. At each new character row it moves the counter forward by a row offset. While display is active it advances the counter on the character clock, either at the full rate or once every two or four character clocks.

The counter value is mapped to memory in one of three ways. Byte mapping passes the value through unchanged. Word mapping shifts it up one place. Double-word mapping rotates it up two places. Word mapping has a selectable 16 KB wrap. During active display, the low bits of the row scan counter can replace address bits 13 and 14 after the mapping, which serves two-bank and four-bank graphics layouts. The output address is registered.

The block also produces the clock enable for the vertical counters, which can run at half the line rate, and the gated horizontal and vertical sync outputs. A controller run bit, cleared by reset, holds both syncs inactive.

Top module: `crtc_addr_gen`

## Requirements
- R1: Byte mapping (`dword_sel`=0, `byte_sel`=1) outputs the counter value unchanged.
- R2: Word mapping (`dword_sel`=0, `byte_sel`=0) outputs counter bits 14:0 on address bits 15:1. Address bit 0 carries counter bit 13 when `wrap_ext`=0 and counter bit 15 when `wrap_ext`=1.
- R3: Double-word mapping (`dword_sel`=1, whatever `byte_sel` is) outputs counter bits 13:0 on address bits 15:2 and counter bits 13:12 on address bits 1:0.
- R4: While `disp_en`=1 and `sub13_off`=0, address bit 13 takes `row_scan[0]`. This is applied after the mapping.
- R5: While `disp_en`=1 and `sub14_off`=0, address bit 14 takes `row_scan[1]`. This is applied after the mapping.
- R6: While `disp_en`=0 the mapped address is output with no substitution.
- R7: While `cclk_en`=1 and `disp_en`=1, the counter advances by one every N enabled clocks. N comes from {`cnt_by4`,`cnt_by2`}: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 2. The counter holds when `disp_en`=0 or `cclk_en`=0.
- R8: `frame_load` sets the counter and the row base to `start_addr`. Otherwise `row_load` adds `row_offset` to the row base and copies the result into the counter. The address output follows one clock after the counter.
- R9: `vcnt_en` pulses one clock after each `hretrace` pulse when `vsel_half`=0, and after every second pulse when `vsel_half`=1.
- R10: While `sync_run`=0, `hsync_o` and `vsync_o` are low one clock later. Otherwise they follow `hsync_in` and `vsync_in` one clock later.
- R11: During reset, `addr_o`, `hsync_o`, `vsync_o` and `vcnt_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cclk_en | input | 1 | Character clock enable |
| disp_en | input | 1 | Active display (1) or blanking (0) |
| frame_load | input | 1 | Load start address at frame start |
| start_addr | input | 16 | Frame start address |
| row_load | input | 1 | Advance row base by the offset |
| row_offset | input | 16 | Per-row address offset |
| row_scan | input | 2 | Low bits of the row scan counter |
| sub13_off | input | 1 | 1 disables substitution into bit 13 |
| sub14_off | input | 1 | 1 disables substitution into bit 14 |
| cnt_by2 | input | 1 | Increment rate select, low bit |
| cnt_by4 | input | 1 | Increment rate select, high bit |
| byte_sel | input | 1 | Byte (1) or word (0) mapping |
| dword_sel | input | 1 | Double-word mapping |
| wrap_ext | input | 1 | Word mapping: 0 wraps at 16 KB |
| vsel_half | input | 1 | Halve the vertical counter rate |
| hretrace | input | 1 | One-clock pulse per horizontal retrace |
| sync_run | input | 1 | Controller run bit; 0 holds syncs low |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| addr_o | output | 16 | Registered display memory address |
| vcnt_en | output | 1 | Vertical counter clock enable |
| hsync_o | output | 1 | Gated horizontal sync |
| vsync_o | output | 1 | Gated vertical sync |

## Verification
A wrong counter value shows on `addr_o` one clock after it arises. Every later character then carries the same offset until the next `frame_load` or `row_load` clears it. A pace divider stuck at the wrong phase gives a step count that is off by one over a short enabled run, so runs of seven enabled clocks at each rate expose it. A wrong phase in the vertical enable toggle shows as a miscount of `vcnt_en` pulses over four retraces.

// File: rtl/crtc_addr_pkg.sv
package crtc_addr_pkg;
  localparam int ADDR_W = 16;
  localparam int PACE_W = 2;
  localparam int SUB_LO_BIT = 13;
  localparam int SUB_HI_BIT = 14;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic [1:0] {MAP_WORD = 2'b00, MAP_BYTE = 2'b01, MAP_DWORD = 2'b10} map_e;

  function automatic map_e decode_map(input logic dword_sel, input logic byte_sel);
    if (dword_sel) return MAP_DWORD;
    else if (byte_sel) return MAP_BYTE;
    else return MAP_WORD;
  endfunction

  // Terminal phase of the pacing divider: rate minus one.
  function automatic logic [PACE_W-1:0] pace_limit(input logic by4, input logic by2);
    case ({by4, by2})
      2'b00: return 2'd0;
      2'b01: return 2'd1;
      2'b10: return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/crtc_pace.sv
module crtc_pace
  import crtc_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic adv,
  input  logic by4,
  input  logic by2,
  output logic step
);
  logic [PACE_W-1:0] ph_q;
  logic [PACE_W-1:0] lim;

  assign lim  = pace_limit(by4, by2);
  assign step = adv && !restart && (ph_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= '0;
    else if (restart) ph_q <= '0;
    else if (adv) ph_q <= (ph_q >= lim) ? '0 : ph_q + 1'b1;
  end

  // R7: with a rate above one, two steps never come back to back
  a_r7_no_double_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lim != '0) |=> (!step || lim == '0));
endmodule

// File: rtl/crtc_lin_cnt.sv
module crtc_lin_cnt
  import crtc_addr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_load,
  input  addr_t start_addr,
  input  logic  row_load,
  input  addr_t row_offset,
  input  logic  step,
  output addr_t cnt
);
  addr_t base_q, cnt_q, next_base;

  assign next_base = base_q + row_offset;
  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (frame_load) begin
      base_q <= start_addr;
      cnt_q  <= start_addr;
    end else if (row_load) begin
      base_q <= next_base;
      cnt_q  <= next_base;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r8_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> cnt == $past(start_addr));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_load && !row_load && !step) |=> $stable(cnt));
endmodule

// File: rtl/crtc_addr_map.sv
module crtc_addr_map
  import crtc_addr_pkg::*;
(
  input  addr_t      cnt,
  input  map_e       mode,
  input  logic       wrap_ext,
  input  logic       disp_en,
  input  logic       sub13_off,
  input  logic       sub14_off,
  input  logic [1:0] row_scan,
  output addr_t      addr
);
  addr_t mapped;

  always_comb begin
    case (mode)
      MAP_BYTE:  mapped = cnt;
      MAP_WORD:  mapped = {cnt[ADDR_W-2:0], (wrap_ext ? cnt[ADDR_W-1] : cnt[SUB_LO_BIT])};
      default:   mapped = {cnt[ADDR_W-3:0], cnt[SUB_LO_BIT:SUB_LO_BIT-1]};
    endcase
  end

  always_comb begin
    addr = mapped;
    if (disp_en && !sub13_off) addr[SUB_LO_BIT] = row_scan[0];
    if (disp_en && !sub14_off) addr[SUB_HI_BIT] = row_scan[1];
  end
endmodule

// File: rtl/crtc_sync_gate.sv
module crtc_sync_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hretrace,
  input  logic vsel_half,
  input  logic sync_run,
  input  logic hsync_in,
  input  logic vsync_in,
  output logic vcnt_en,
  output logic hsync_o,
  output logic vsync_o
);
  logic phase_q, ven_q, hs_q, vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      ven_q   <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
    end else begin
      if (hretrace) phase_q <= !phase_q;
      ven_q <= hretrace && (!vsel_half || phase_q);
      hs_q  <= hsync_in && sync_run;
      vs_q  <= vsync_in && sync_run;
    end
  end

  assign vcnt_en = ven_q;
  assign hsync_o = hs_q;
  assign vsync_o = vs_q;

  a_r9_needs_retrace: assert property (@(posedge clk) disable iff (!rst_n)
    !hretrace |=> !vcnt_en);
  a_r9_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (hretrace && !vsel_half) |=> vcnt_en);
  a_r10_sync_held: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_run |=> (!hsync_o && !vsync_o));
endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen
  import crtc_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cclk_en,
  input  logic              disp_en,
  input  logic              frame_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              row_load,
  input  logic [ADDR_W-1:0] row_offset,
  input  logic [1:0]        row_scan,
  input  logic              sub13_off,
  input  logic              sub14_off,
  input  logic              cnt_by2,
  input  logic              cnt_by4,
  input  logic              byte_sel,
  input  logic              dword_sel,
  input  logic              wrap_ext,
  input  logic              vsel_half,
  input  logic              hretrace,
  input  logic              sync_run,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vcnt_en,
  output logic              hsync_o,
  output logic              vsync_o
);
  logic  step;
  addr_t cnt, addr_d, addr_q;
  map_e  mode;

  assign mode = decode_map(dword_sel, byte_sel);

  crtc_pace u_pace (
    .clk(clk), .rst_n(rst_n), .restart(frame_load || row_load),
    .adv(cclk_en && disp_en), .by4(cnt_by4), .by2(cnt_by2), .step(step)
  );

  crtc_lin_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load), .start_addr(start_addr),
    .row_load(row_load), .row_offset(row_offset), .step(step), .cnt(cnt)
  );

  crtc_addr_map u_map (
    .cnt(cnt), .mode(mode), .wrap_ext(wrap_ext), .disp_en(disp_en),
    .sub13_off(sub13_off), .sub14_off(sub14_off), .row_scan(row_scan), .addr(addr_d)
  );

  crtc_sync_gate u_sync (
    .clk(clk), .rst_n(rst_n), .hretrace(hretrace), .vsel_half(vsel_half),
    .sync_run(sync_run), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .vcnt_en(vcnt_en), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  a_r4_row_bit13: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !sub13_off) |=> addr_o[SUB_LO_BIT] == $past(row_scan[0]));
  a_r5_row_bit14: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && !sub14_off) |=> addr_o[SUB_HI_BIT] == $past(row_scan[1]));
  a_r6_blank_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en && byte_sel && !dword_sel) |=> addr_o == $past(cnt));
  a_r1_byte_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_sel && !dword_sel && sub13_off && sub14_off) |=> addr_o == $past(cnt));
endmodule

// File: tb/crtc_addr_gen_test.sv
module crtc_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cclk_en = 0, disp_en = 0, frame_load = 0, row_load = 0;
  logic [15:0] start_addr = '0, row_offset = '0;
  logic [1:0] row_scan = '0;
  logic sub13_off = 1, sub14_off = 1, cnt_by2 = 0, cnt_by4 = 0;
  logic byte_sel = 1, dword_sel = 0, wrap_ext = 0, vsel_half = 0;
  logic hretrace = 0, sync_run = 0, hsync_in = 0, vsync_in = 0;
  logic [15:0] addr_o;
  logic vcnt_en, hsync_o, vsync_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crtc_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .cclk_en(cclk_en), .disp_en(disp_en),
    .frame_load(frame_load), .start_addr(start_addr), .row_load(row_load),
    .row_offset(row_offset), .row_scan(row_scan), .sub13_off(sub13_off),
    .sub14_off(sub14_off), .cnt_by2(cnt_by2), .cnt_by4(cnt_by4),
    .byte_sel(byte_sel), .dword_sel(dword_sel), .wrap_ext(wrap_ext),
    .vsel_half(vsel_half), .hretrace(hretrace), .sync_run(sync_run),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .addr_o(addr_o),
    .vcnt_en(vcnt_en), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  // {start[39:24], ctrl[23:19] = dword,byte,wrap,sub14_off,sub13_off, rs[18:17], de[16], exp[15:0]}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {16'hA5C3, 5'b01011, 2'b00, 1'b0, 16'hA5C3},  // R1 byte
    {16'h25C3, 5'b00011, 2'b00, 1'b0, 16'h4B87},  // R2 word, 16 KB wrap
    {16'h25C3, 5'b00111, 2'b00, 1'b0, 16'h4B86},  // R2 word, extended
    {16'hA5C3, 5'b10011, 2'b00, 1'b0, 16'h970E},  // R3 double word
    {16'hA5C3, 5'b01010, 2'b00, 1'b1, 16'h85C3},  // R4 bit 13
    {16'hA5C3, 5'b01001, 2'b10, 1'b1, 16'hE5C3},  // R5 bit 14
    {16'hA5C3, 5'b01000, 2'b10, 1'b1, 16'hC5C3},  // R4 R5 both
    {16'hA5C3, 5'b01000, 2'b10, 1'b0, 16'hA5C3},  // R6 blanking
    {16'h25C3, 5'b00000, 2'b01, 1'b1, 16'h2B87},  // R2 R4 R5 word then substitute
    {16'hA5C3, 5'b10010, 2'b01, 1'b1, 16'hB70E}   // R3 R4 double word then substitute
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic load_frame(input logic [15:0] s);
    @(negedge clk);
    start_addr = s; frame_load = 1; cclk_en = 0;
    @(negedge clk);
    frame_load = 0;
  endtask

  task automatic pace_run(input logic b4, input logic b2, input int n, input logic de,
                          input logic [15:0] exp, input string req);
    byte_sel = 1; dword_sel = 0; sub13_off = 1; sub14_off = 1;
    cnt_by4 = b4; cnt_by2 = b2; disp_en = de;
    load_frame(16'h1000);
    cclk_en = 1;
    repeat (n) @(negedge clk);
    cclk_en = 0;
    @(negedge clk);
    check(req, addr_o, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int pulses;
    // R11 reset state
    sync_run = 1; hsync_in = 1; vsync_in = 1; hretrace = 1;
    repeat (3) @(negedge clk);
    check("R11 addr", addr_o, 16'h0);
    check("R11 syncs/vcnt", {13'b0, hsync_o, vsync_o, vcnt_en}, 16'h0);
    hretrace = 0; sync_run = 0;
    rst_n = 1;

    // R10 sync gating
    @(negedge clk); @(negedge clk);
    check("R10 held", {14'b0, hsync_o, vsync_o}, 16'h0);
    sync_run = 1;
    @(negedge clk);
    check("R10 run", {14'b0, hsync_o, vsync_o}, 16'h3);
    hsync_in = 0;
    @(negedge clk);
    check("R10 follow", {14'b0, hsync_o, vsync_o}, 16'h1);

    // Table of mapping vectors (R1 to R6)
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      dword_sel = v[23]; byte_sel = v[22]; wrap_ext = v[21];
      sub14_off = v[20]; sub13_off = v[19]; row_scan = v[18:17]; disp_en = v[16];
      load_frame(v[39:24]);
      @(negedge clk);
      check($sformatf("R1-6 vector %0d", i), addr_o, v[15:0]);
    end
    row_scan = 0;

    // R7 pacing, 7 enabled clocks from 0x1000
    pace_run(0, 0, 7, 1, 16'h1007, "R7 rate1");
    pace_run(0, 1, 7, 1, 16'h1003, "R7 rate2");
    pace_run(1, 0, 7, 1, 16'h1001, "R7 rate4");
    pace_run(1, 1, 7, 1, 16'h1003, "R7 code11");
    pace_run(0, 0, 5, 0, 16'h1000, "R7 blank hold");

    // R8 row loads
    cnt_by4 = 0; cnt_by2 = 0; disp_en = 0;
    load_frame(16'h0100);
    @(negedge clk);
    row_offset = 16'h0050; row_load = 1;
    @(negedge clk);
    row_load = 0;
    @(negedge clk);
    check("R8 row1", addr_o, 16'h0150);
    row_load = 1;
    @(negedge clk);
    row_load = 0;
    @(negedge clk);
    check("R8 row2", addr_o, 16'h01A0);
    load_frame(16'h0100);
    @(negedge clk);
    check("R8 frame reload", addr_o, 16'h0100);

    // R9 vertical enable
    for (int m = 0; m < 2; m++) begin
      vsel_half = logic'(m);
      pulses = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); hretrace = 1;
        @(negedge clk); hretrace = 0;
        if (vcnt_en) pulses++;
        @(negedge clk);
        if (vcnt_en) pulses++;
      end
      check($sformatf("R9 half=%0d", m), 16'(pulses), (m == 0) ? 16'd4 : 16'd2);
    end

    summary();
  end
endmodule